// File: doc/BRIEF.md
# Prioritized Interrupt and Modem-Status Unit

This unit merges four level-style service conditions into one interrupt request for a serial controller. The four conditions are a receive line-status condition, a full receive buffer, an empty transmit buffer and a change on the modem inputs. Each condition has its own enable bit. Software reads a vector byte that names the most urgent enabled condition and carries an active-low pending flag.

The same unit watches four active-low modem inputs: carrier detect, ring indicator, data-set ready and clear-to-send. Each input passes through a synchroniser. Software reads each input's present level, complemented, and a sticky change bit per input. Reading the modem status byte clears the change bits. The OR of the change bits is the modem interrupt condition. The unit does no bus address decoding. The enable write strobe and the status read strobe come in as separate signals.

Top module: `irq_modem_unit`

## Requirements
- R1: After reset the enable byte reads 0x00, the vector byte reads 0x01, `irq` is low, and with all modem inputs high the modem status byte reads 0x00.
- R2: A write to the enable byte stores bits 3:0: bit 0 receive-buffer full, bit 1 transmit-buffer empty, bit 2 line status, bit 3 modem change. Bits 7:4 always read zero.
- R3: The vector code in bits 2:1 is the highest-priority condition that is both pending and enabled. The codes are 11 for line status (highest), 10 for receive-buffer full, 01 for transmit-buffer empty and 00 for modem change (lowest).
- R4: Vector bit 0 reads 0 while any enabled condition is pending and 1 otherwise. The code reads 00 when nothing is pending, and bits 7:3 read zero.
- R5: `irq` is high exactly when at least one enabled condition is pending, and drops once the last one clears or is disabled.
- R6: Modem status bits 7, 6, 5 and 4 report the complemented synchronised levels of carrier detect, ring, data-set ready and clear-to-send. A level change on a pin shows there two clock edges after it is sampled.
- R7: The change bits for carrier detect (bit 3), data-set ready (bit 1) and clear-to-send (bit 0) are set by either edge of their pin and stay set until a status read.
- R8: The ring change bit (bit 2) is set only when the ring input falls. A rising ring input leaves it unchanged.
- R9: A status read clears every change bit at that clock edge. A change detected at that same edge leaves its bit set.
- R10: The modem interrupt condition is pending whenever any change bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | 1 | Receive line-status condition (level) |
| src_rxfull | input | 1 | Receive buffer full (level) |
| src_txempty | input | 1 | Transmit buffer empty (level) |
| en_wr | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte write data |
| en_rdata | output | 8 | Enable byte readback |
| vec_rdata | output | 8 | Interrupt vector byte |
| irq | output | 1 | Interrupt request, active high |
| msr_rd | input | 1 | Modem status read strobe; clears change bits |
| msr_rdata | output | 8 | Modem status byte |
| dcd_n | input | 1 | Carrier detect, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dsr_n | input | 1 | Data-set ready, active low |
| cts_n | input | 1 | Clear-to-send, active low |

## Verification
The hardest case to reach is a status read that lands on the same clock edge at which a synchronised pin change is detected. The clear and the new event then compete for the same bit. The stimulus moves a pin at a falling edge, lets two rising edges pass through the synchroniser, and raises the read strobe for exactly the third edge. It then checks that the change bit is still set. The priority logic is swept over all sixteen enable masks against all sixteen pending patterns. The modem pending state is created by toggling a pin, and it is cleared by a read before the next pattern.

// File: rtl/imu_pkg.sv
package imu_pkg;
  localparam int NSRC    = 4;
  localparam int NMODEM  = 4;
  // enable / pending bit positions
  localparam int EN_RXF  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
  // modem pin index: 3 carrier, 2 ring, 1 data-set ready, 0 clear-to-send
  localparam int RING_IDX = 2;

  typedef enum logic [1:0] {
    VEC_MDM  = 2'b00,
    VEC_TXE  = 2'b01,
    VEC_RXF  = 2'b10,
    VEC_LINE = 2'b11
  } vec_code_e;

  function automatic vec_code_e pick_code(input logic [NSRC-1:0] m);
    if (m[EN_LINE])     return VEC_LINE;
    else if (m[EN_RXF]) return VEC_RXF;
    else if (m[EN_TXE]) return VEC_TXE;
    else                return VEC_MDM;
  endfunction

  function automatic logic [7:0] pack_vector(input logic [NSRC-1:0] m);
    vec_code_e c;
    c = pick_code(m);
    return {5'b0, c, ~(|m)};
  endfunction
endpackage

// File: rtl/imu_sync.sv
module imu_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_in;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/imu_modem_track.sv
module imu_modem_track
  import imu_pkg::*;
#(
  parameter int N = NMODEM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  input  logic         rd_clr,
  output logic [N-1:0] status,
  output logic [N-1:0] delta,
  output logic         any_delta
);
  logic [N-1:0] prev_n;
  logic [N-1:0] evt;
  logic         ring_rose;

  for (genvar i = 0; i < N; i++) begin : g_evt
    if (i == RING_IDX) begin : g_ring
      assign evt[i] = prev_n[i] & ~lvl_n[i];
    end else begin : g_any
      assign evt[i] = prev_n[i] ^ lvl_n[i];
    end
  end

  assign ring_rose = ~prev_n[RING_IDX] & lvl_n[RING_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= '1;
      delta  <= '0;
    end else begin
      prev_n <= lvl_n;
      delta  <= rd_clr ? evt : (delta | evt);
    end
  end

  assign status    = ~lvl_n;
  assign any_delta = |delta;

  AST_DELTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((delta & $past(delta)) == $past(delta)));          // R7
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (evt == '0)) |=> (delta == '0));                     // R9
  AST_RING_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta[RING_IDX] && ring_rose) |=> !delta[RING_IDX]);          // R8
endmodule

// File: rtl/imu_prio.sv
module imu_prio
  import imu_pkg::*;
(
  input  logic [NSRC-1:0] masked,
  output logic [7:0]      vec
);
  assign vec = pack_vector(masked);
endmodule

// File: rtl/irq_modem_unit.sv
module irq_modem_unit
  import imu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_line,
  input  logic       src_rxfull,
  input  logic       src_txempty,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  output logic [7:0] vec_rdata,
  output logic       irq,
  input  logic       msr_rd,
  output logic [7:0] msr_rdata,
  input  logic       dcd_n,
  input  logic       ri_n,
  input  logic       dsr_n,
  input  logic       cts_n
);
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   masked;
  logic [NMODEM-1:0] pins_sync;
  logic [NMODEM-1:0] mstat;
  logic [NMODEM-1:0] mdelta;
  logic              mdm_evt;
  logic              unused_hi;

  assign unused_hi = ^en_wdata[7:NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata[NSRC-1:0];
  end
  assign en_rdata = {{(8-NSRC){1'b0}}, en_q};

  imu_sync #(.WIDTH(NMODEM), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({dcd_n, ri_n, dsr_n, cts_n}),
    .d_out (pins_sync)
  );

  imu_modem_track #(.N(NMODEM)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_n     (pins_sync),
    .rd_clr    (msr_rd),
    .status    (mstat),
    .delta     (mdelta),
    .any_delta (mdm_evt)
  );
  assign msr_rdata = {mstat, mdelta};

  always_comb begin
    pend          = '0;
    pend[EN_RXF]  = src_rxfull;
    pend[EN_TXE]  = src_txempty;
    pend[EN_LINE] = src_line;
    pend[EN_MDM]  = mdm_evt;
  end
  assign masked = pend & en_q;
  assign irq    = |masked;

  imu_prio u_prio (
    .masked (masked),
    .vec    (vec_rdata)
  );

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_line && en_q[EN_LINE]) |-> (vec_rdata[2:1] == 2'b11));     // R3
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq != vec_rdata[0]);                                           // R5
  AST_MODEM_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((msr_rdata[3:0] != 4'h0) && en_rdata[3]) |-> irq);             // R10
endmodule

// File: tb/tb_irq_modem_unit.sv
module tb_irq_modem_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_line = 0, src_rxfull = 0, src_txempty = 0;
  logic       en_wr = 0;
  logic [7:0] en_wdata = 0;
  logic [7:0] en_rdata, vec_rdata, msr_rdata;
  logic       irq;
  logic       msr_rd = 0;
  logic [3:0] pins_n = 4'hF;   // 3 carrier, 2 ring, 1 dsr, 0 cts

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_modem_unit dut (
    .clk(clk), .rst_n(rst_n),
    .src_line(src_line), .src_rxfull(src_rxfull), .src_txempty(src_txempty),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .vec_rdata(vec_rdata), .irq(irq),
    .msr_rd(msr_rd), .msr_rdata(msr_rdata),
    .dcd_n(pins_n[3]), .ri_n(pins_n[2]), .dsr_n(pins_n[1]), .cts_n(pins_n[0])
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; step(1); en_wr = 0;
  endtask

  task automatic read_msr(output logic [7:0] v);
    msr_rd = 1; v = msr_rdata; step(1); msr_rd = 0;
  endtask

  // expected vector from a masked pending set {modem,line,tx,rx}
  function automatic logic [7:0] exp_vec(input logic [3:0] m);
    int code;
    code = m[2] ? 3 : (m[0] ? 2 : (m[1] ? 1 : 0));
    return 8'(code * 2 + ((m == 0) ? 1 : 0));
  endfunction

  initial begin
    logic [7:0] r;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check(en_rdata, 8'h00, "R1 enable");
    check(vec_rdata, 8'h01, "R1 vector");
    check({7'b0, irq}, 8'h00, "R1 irq");
    check(msr_rdata, 8'h00, "R1 modem status");

    // R2 upper bits read zero
    write_en(8'hFF);
    check(en_rdata, 8'h0F, "R2 enable mask");
    write_en(8'hA5);
    check(en_rdata, 8'h05, "R2 enable mask");

    // R6 R7 R8 R9 per pin
    for (int i = 0; i < 4; i++) begin
      pins_n[i] = 0;
      step(2);
      check(msr_rdata & 8'hF0, 8'(1 << (4 + i)), "R6 level");
      step(1);
      check(msr_rdata, 8'((1 << (4 + i)) | (1 << i)), "R7/R8 falling edge delta");
      read_msr(r);
      check(msr_rdata, 8'(1 << (4 + i)), "R9 read clears");
      pins_n[i] = 1;
      step(3);
      check(msr_rdata, (i == 2) ? 8'h00 : 8'(1 << i), "R7/R8 rising edge delta");
      read_msr(r);
      check(msr_rdata, 8'h00, "R9 read clears");
    end

    // R9 change coinciding with the read edge
    pins_n[0] = 0;
    step(2);
    msr_rd = 1; step(1); msr_rd = 0;
    check(msr_rdata & 8'h01, 8'h01, "R9 coincident change kept");
    read_msr(r);
    pins_n[0] = 1; step(3); read_msr(r);
    check(msr_rdata, 8'h00, "R9 cleanup");

    // R3 R4 R5 R10 sweep: pending pattern x enable mask
    for (int s = 0; s < 16; s++) begin
      src_rxfull  = s[0];
      src_txempty = s[1];
      src_line    = s[2];
      if (s[3]) begin
        pins_n[0] = ~pins_n[0];
        step(3);
      end else begin
        read_msr(r);
      end
      for (int e = 0; e < 16; e++) begin
        logic [3:0] m;
        write_en(8'(e));
        m = 4'(s) & 4'(e);
        check(vec_rdata, exp_vec(m), "R3/R4/R10 vector");
        check({7'b0, irq}, {7'b0, (m != 0)}, "R5/R10 irq");
      end
      read_msr(r);
    end
    // R5 drop after clearing the last condition
    src_rxfull = 0; src_txempty = 0; src_line = 1;
    write_en(8'h04); step(1);
    check({7'b0, irq}, 8'h01, "R5 set");
    src_line = 0; step(1);
    check({7'b0, irq}, 8'h00, "R5 drop");
    check(vec_rdata, 8'h01, "R4 idle vector");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule